// File: doc/BRIEF.md
# SMBus Power-Management Target Interface

This block is the serial management port of a power-management device. It watches the open-drain clock and data lines of a two-wire SMBus/PMBus segment, synchronises and filters them into a fast system clock domain, and answers as a target at a fixed 7-bit address. Controllers can write a byte into a small bank of configuration registers, read a byte back with a command-then-read sequence, or fetch a byte with a bare receive operation that reuses the last command code. Two single-byte commands need no data: one asks external storage to commit the current settings, and the other clears the communication error flag.

Packet error checking is chosen per transaction. A trailing checksum byte is present only when the controller clocks it before STOP. Writes take effect at STOP and only if they pass the checksum rules. A configuration input can make the checksum mandatory for writes. Fault inputs and checksum failures pull an active-low alert line. The controller locates the alerting target through the alert response address, and the target then releases the line. The line comes back if a fault input is still active, but not for a communication error alone.

Top module: `smbus_target`

## Requirements
- R1: START is a falling SDA and STOP is a rising SDA while SCL is high. Pulses on SCL or SDA shorter than FILT_LEN system clocks are ignored.
- R2: A first byte equal to {TGT_ADDR, R/W} is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge and changes nothing.
- R3: A write (address+W, command, data, STOP) to a command code in REG_BASE..REG_BASE+NREGS-1 updates that register at STOP. A read (address+W, command, repeated START, address+R) returns it MSB first.
- R4: A receive byte (address+R, then data) returns the register selected by the most recent command code.
- R5: The checksum is CRC-8 with polynomial 0x07 and initial value 0x00, MSB first. It covers every address byte, including the repeated-start address, and every data byte. On a read, a controller ACK after the data byte makes the target send the checksum byte.
- R6: A write whose trailing checksum byte is wrong is discarded. It sets bit 0 of the status register (command 0x7E, other bits 0) and asserts the alert.
- R7: While pec_required_i is high, a write that ends without a checksum byte is discarded and does not touch the status register.
- R8: Command 0x15 sent alone, with or without a correct checksum, pulses store_o high for exactly one cycle after STOP. A wrong checksum gives no pulse.
- R9: Command 0x03 sent alone clears status bit 0.
- R10: alert_n_o goes low while any fault_i bit is high or after a communication error. A read from address 7'h0C is acknowledged only while the alert is low, returns {TGT_ADDR, 1'b0} and releases the alert.
- R11: After an alert response the alert is asserted again if any fault_i bit is still high. A pending communication error alone does not assert it again.
- R12: When the controller NACKs a byte sent by the target, the target releases SDA until STOP or a repeated START.
- R13: With a 50 MHz system clock and the default filter, transfers work at 100 kHz, 400 kHz and 1 MHz SCL.
- R14: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| pec_required_i | input | 1 | High: writes without a checksum byte are rejected |
| fault_i | input | NFAULT | Active-high fault conditions that raise the alert |
| sda_oe_o | output | 1 | High pulls the data line low |
| alert_n_o | output | 1 | Active-low alert |
| store_o | output | 1 | One-cycle request to commit settings to storage |

## Verification
The bench sweeps writes and read-backs over every register and pattern. It compares the checksum byte from the target with a bitwise CRC that the bench computes itself, so a design that skipped the repeated-start address in the CRC would send the wrong byte. It provokes checksum failures, missing checksums under the mandatory mode, and commit commands with and without checksums. A design that applied writes before STOP or ignored the checksum would leave the wrong register value or store pulse count. It walks the alert through faults, communication errors and alert responses, catching a design that re-asserts for a communication error or fails to re-assert for a persistent fault. It also injects one-cycle glitches, clocks past a NACK and runs at all three bus rates, which exposes a missing filter, an SDA driver left active after a NACK, or timing that works at only one speed.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
    localparam logic [6:0] ARA_ADDR   = 7'h0C;
    localparam logic [7:0] CMD_CLRERR = 8'h03;
    localparam logic [7:0] CMD_COMMIT = 8'h15;
    localparam logic [7:0] CMD_STATUS = 8'h7E;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_ACK, PH_RX, PH_TX, PH_ACKCHK, PH_WAIT
    } phase_e;

    // one byte through CRC-8, polynomial 0x07, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] data);
        logic [7:0] c;
        c = crc_in ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    scl_m;
        logic [1:0]    sda_m;
        logic [CW-1:0] scl_c;
        logic [CW-1:0] sda_c;
        logic          scl_f;
        logic          sda_f;
        logic          scl_p;
        logic          sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.scl_m = {q.scl_m[0], scl_i};
        d.sda_m = {q.sda_m[0], sda_i};
        // a level must differ for FILT_LEN straight cycles before it is taken
        if (q.scl_m[1] != q.scl_f) begin
            if (q.scl_c == CW'(FILT_LEN - 1)) begin
                d.scl_f = q.scl_m[1];
                d.scl_c = '0;
            end else begin
                d.scl_c = q.scl_c + 1'b1;
            end
        end else begin
            d.scl_c = '0;
        end
        if (q.sda_m[1] != q.sda_f) begin
            if (q.sda_c == CW'(FILT_LEN - 1)) begin
                d.sda_f = q.sda_m[1];
                d.sda_c = '0;
            end else begin
                d.sda_c = q.sda_c + 1'b1;
            end
        end else begin
            d.sda_c = '0;
        end
        d.scl_p = q.scl_f;
        d.sda_p = q.sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_m: 2'b11, sda_m: 2'b11, scl_c: '0, sda_c: '0,
                   scl_f: 1'b1, sda_f: 1'b1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_o      = q.scl_f;
    assign sda_o      = q.sda_f;
    assign scl_rise_o = q.scl_f & ~q.scl_p;
    assign scl_fall_o = ~q.scl_f & q.scl_p;
    assign start_o    = q.scl_f & q.scl_p & q.sda_p & ~q.sda_f;
    assign stop_o     = q.scl_f & q.scl_p & ~q.sda_p & q.sda_f;
endmodule

// File: rtl/smbt_regs.sv
module smbt_regs
    import smbt_pkg::*;
#(
    parameter int          NREGS    = 4,
    parameter logic [7:0]  REG_BASE = 8'h20,
    parameter int          NFAULT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_cmd_i,
    input  logic [7:0]        wr_data_i,
    input  logic              clr_err_i,
    input  logic              err_set_i,
    input  logic              ara_done_i,
    input  logic [NFAULT-1:0] fault_i,
    input  logic [7:0]        rd_cmd_i,
    output logic [7:0]        rd_data_o,
    output logic              alert_o
);
    typedef struct packed {
        logic [NREGS-1:0][7:0] regs;
        logic                  err;
        logic                  alert;
    } rf_t;

    rf_t q, d;
    logic [NREGS-1:0] hit_wr, hit_rd;

    // per-register command decode
    for (genvar g = 0; g < NREGS; g++) begin : g_dec
        assign hit_wr[g] = (int'(wr_cmd_i) == int'(REG_BASE) + g);
        assign hit_rd[g] = (int'(rd_cmd_i) == int'(REG_BASE) + g);
    end

    always_comb begin
        d = q;
        for (int i = 0; i < NREGS; i++) begin
            if (wr_en_i && hit_wr[i]) d.regs[i] = wr_data_i;
        end
        if (clr_err_i) d.err = 1'b0;
        if (err_set_i) d.err = 1'b1;
        if (ara_done_i)                      d.alert = 1'b0;
        else if ((|fault_i) || err_set_i)    d.alert = 1'b1;
    end

    always_comb begin
        rd_data_o = 8'hFF;
        if (rd_cmd_i == CMD_STATUS) rd_data_o = {7'b0, q.err};
        for (int i = 0; i < NREGS; i++) begin
            if (hit_rd[i]) rd_data_o = q.regs[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign alert_o = q.alert;

    // R10
    alert_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ara_done_i |=> !alert_o);

    // R11
    fault_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_o && (|fault_i) && !ara_done_i) |=> alert_o);

    // R6
    err_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set_i && !ara_done_i) |=> (alert_o && rd_cmd_i != CMD_STATUS || alert_o && rd_data_o[0]));
endmodule

// File: rtl/smbus_target.sv
module smbus_target
    import smbt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h5A,
    parameter int         NREGS    = 4,
    parameter logic [7:0] REG_BASE = 8'h20,
    parameter int         NFAULT   = 2,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pec_required_i,
    input  logic [NFAULT-1:0] fault_i,
    output logic              sda_oe_o,
    output logic              alert_n_o,
    output logic              store_o
);
    typedef struct packed {
        phase_e     ph;
        logic [3:0] bcnt;
        logic [7:0] sh;
        logic [7:0] crc;
        logic [7:0] cmd;
        logic [7:0] wdat;
        logic [1:0] nb;
        logic       in_txn;
        logic       wr_dir;
        logic       rd_dir;
        logic       ara;
        logic       acked;
        logic       pec_tx;
        logic       oe;
        logic       store;
    } tgt_t;

    tgt_t q, d;

    logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;
    logic wr_en, clr_err, err_set, ara_done, alert;
    logic [7:0] rd_data;

    smbt_sync #(.FILT_LEN(FILT_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_f), .sda_o(sda_f), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_c), .stop_o(stop_c)
    );

    smbt_regs #(.NREGS(NREGS), .REG_BASE(REG_BASE), .NFAULT(NFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_cmd_i(q.cmd), .wr_data_i(q.wdat),
        .clr_err_i(clr_err), .err_set_i(err_set), .ara_done_i(ara_done),
        .fault_i(fault_i), .rd_cmd_i(q.cmd), .rd_data_o(rd_data), .alert_o(alert)
    );

    logic       short_cmd, no_pec, has_pec, accept, commit;
    logic [1:0] base_n;
    logic       match_w, match_r, match_ara;
    logic [7:0] tx_byte;

    always_comb begin
        d       = q;
        d.store = 1'b0;
        wr_en   = 1'b0;
        clr_err = 1'b0;
        err_set = 1'b0;
        ara_done = 1'b0;

        short_cmd = (q.cmd == CMD_COMMIT) || (q.cmd == CMD_CLRERR);
        base_n    = short_cmd ? 2'd1 : 2'd2;
        no_pec    = (q.nb == base_n);
        has_pec   = (q.nb == base_n + 2'd1);
        accept    = (no_pec && !pec_required_i) || (has_pec && q.crc == 8'h00);
        commit    = q.in_txn && q.wr_dir && accept;

        match_w   = (q.sh[7:1] == TGT_ADDR) && !q.sh[0];
        match_r   = (q.sh[7:1] == TGT_ADDR) && q.sh[0];
        match_ara = (q.sh[7:1] == ARA_ADDR) && q.sh[0] && alert;
        tx_byte   = q.ara ? {TGT_ADDR, 1'b0} : rd_data;

        if (stop_c) begin
            if (commit) begin
                if (q.cmd == CMD_COMMIT)      d.store = 1'b1;
                else if (q.cmd == CMD_CLRERR) clr_err = 1'b1;
                else                          wr_en   = 1'b1;
            end
            err_set  = q.in_txn && q.wr_dir && has_pec && (q.crc != 8'h00);
            d.ph     = PH_IDLE;
            d.oe     = 1'b0;
            d.in_txn = 1'b0;
            d.wr_dir = 1'b0;
        end else if (start_c) begin
            if (!q.in_txn) begin
                d.crc    = 8'h00;
                d.nb     = 2'd0;
                d.wr_dir = 1'b0;
            end
            d.in_txn = 1'b1;
            d.ph     = PH_ADDR;
            d.bcnt   = 4'd0;
            d.oe     = 1'b0;
            d.ara    = 1'b0;
        end else begin
            unique case (q.ph)
                PH_ADDR, PH_RX: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[6:0], sda_f};
                        d.bcnt = q.bcnt + 4'd1;
                    end
                    if (scl_fall && q.bcnt == 4'd8) begin
                        d.bcnt = 4'd0;
                        if (q.ph == PH_ADDR) begin
                            if (match_w || match_r || match_ara) begin
                                d.crc    = crc8_step(q.crc, q.sh);
                                d.oe     = 1'b1;
                                d.ph     = PH_ACK;
                                d.rd_dir = q.sh[0];
                                d.ara    = match_ara;
                                d.wr_dir = match_w;
                                if (match_w) d.nb = 2'd0;
                            end else begin
                                d.ph = PH_WAIT;
                            end
                        end else begin
                            d.crc = crc8_step(q.crc, q.sh);
                            if (q.nb == 2'd0) d.cmd  = q.sh;
                            if (q.nb == 2'd1) d.wdat = q.sh;
                            if (q.nb != 2'd3) d.nb   = q.nb + 2'd1;
                            d.oe = 1'b1;
                            d.ph = PH_ACK;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.bcnt = 4'd0;
                        if (q.rd_dir) begin
                            d.sh     = tx_byte;
                            d.crc    = crc8_step(q.crc, tx_byte);
                            d.oe     = ~tx_byte[7];
                            d.pec_tx = 1'b0;
                            d.ph     = PH_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.ph = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bcnt == 4'd7) begin
                            d.oe = 1'b0;
                            d.ph = PH_ACKCHK;
                            ara_done = q.ara && !q.pec_tx;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bcnt = q.bcnt + 4'd1;
                        end
                    end
                end
                PH_ACKCHK: begin
                    if (scl_rise) d.acked = ~sda_f;
                    if (scl_fall) begin
                        if (q.acked && !q.pec_tx) begin
                            d.sh     = q.crc;
                            d.oe     = ~q.crc[7];
                            d.pec_tx = 1'b1;
                            d.bcnt   = 4'd0;
                            d.ph     = PH_TX;
                        end else begin
                            d.ph = PH_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_oe_o  = q.oe;
    assign alert_n_o = ~alert;
    assign store_o   = q.store;

    // R14
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe_o));

    // R8
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |=> !store_o);

    // R12
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_WAIT) |-> !sda_oe_o);
endmodule

// File: tb/smbus_target_tb.sv
module smbus_target_tb;
    localparam logic [6:0] ADDR = 7'h5A;
    localparam logic [6:0] ARA  = 7'h0C;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic sda_oe, sda_bus, alert_n, store;
    logic pec_req = 1'b0;
    logic [1:0] fault = 2'b00;
    assign sda_bus = sda_drv & ~sda_oe;

    int q_cyc = 12;
    int n_chk = 0, n_fail = 0, store_cnt = 0;
    bit glitch_en = 1'b0, done = 1'b0;

    smbus_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
        .pec_required_i(pec_req), .fault_i(fault),
        .sda_oe_o(sda_oe), .alert_n_o(alert_n), .store_o(store)
    );

    always @(posedge clk) if (rst_n && store) store_cnt++;

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ b[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic bus_start();
        sda_drv = 1'b1; waitc(q_cyc);
        scl_drv = 1'b1; waitc(q_cyc);
        sda_drv = 1'b0; waitc(q_cyc);
        scl_drv = 1'b0; waitc(q_cyc);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; waitc(q_cyc);
        scl_drv = 1'b1; waitc(q_cyc);
        sda_drv = 1'b1; waitc(2 * q_cyc);
    endtask

    task automatic wbit(input logic b);
        sda_drv = b;
        if (glitch_en) begin
            waitc(q_cyc / 2); scl_drv = 1'b1; waitc(1); scl_drv = 1'b0;
            waitc(q_cyc - q_cyc / 2 - 1);
        end else begin
            waitc(q_cyc);
        end
        scl_drv = 1'b1;
        if (glitch_en && b) begin
            waitc(q_cyc); sda_drv = 1'b0; waitc(1); sda_drv = 1'b1; waitc(q_cyc - 1);
        end else begin
            waitc(2 * q_cyc);
        end
        scl_drv = 1'b0; waitc(q_cyc);
    endtask

    task automatic rbit(output logic b);
        sda_drv = 1'b1; waitc(q_cyc);
        scl_drv = 1'b1; waitc(q_cyc);
        b = sda_bus;    waitc(q_cyc);
        scl_drv = 1'b0; waitc(q_cyc);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(ack);
    endtask

    task automatic rbyte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) rbit(b[i]);
    endtask

    // pmode: 0 no checksum, 1 correct checksum, 2 corrupted checksum
    task automatic send_frame(input logic [6:0] a7, input logic [7:0] cmd, input logic [7:0] data,
                              input bit with_data, input int pmode, output logic ack0);
        logic [7:0] c;
        logic a;
        c = crc_b(8'h00, {a7, 1'b0});
        bus_start();
        wbyte({a7, 1'b0}, ack0);
        c = crc_b(c, cmd); wbyte(cmd, a);
        if (with_data) begin c = crc_b(c, data); wbyte(data, a); end
        if (pmode == 1) wbyte(c, a);
        if (pmode == 2) wbyte(c ^ 8'h21, a);
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] cmd, input bit use_pec, output logic [7:0] data,
                            output logic [7:0] pec, output logic [7:0] exp_pec);
        logic a;
        bus_start();
        wbyte({ADDR, 1'b0}, a);
        wbyte(cmd, a);
        bus_start();
        wbyte({ADDR, 1'b1}, a);
        rbyte(data);
        exp_pec = crc_b(crc_b(crc_b(crc_b(8'h00, {ADDR, 1'b0}), cmd), {ADDR, 1'b1}), data);
        pec = 8'h00;
        if (use_pec) begin wbit(1'b0); rbyte(pec); end
        wbit(1'b1);
        bus_stop();
    endtask

    task automatic recv(input logic [6:0] a7, output logic ack, output logic [7:0] data);
        bus_start();
        wbyte({a7, 1'b1}, ack);
        rbyte(data);
        wbit(1'b1);
        bus_stop();
    endtask

    task automatic expect_reg(input logic [7:0] cmd, input logic [7:0] exp, input string req);
        logic [7:0] v, p, ep;
        read_reg(cmd, 1'b0, v, p, ep);
        check(v == exp, req, v, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R13 actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v, p, ep;
        logic [7:0] vals [4];
        int sc;
        waitc(10);
        rst_n = 1'b1;
        waitc(5);
        check(alert_n == 1'b1, "R10 reset alert", alert_n, 1);
        check(sda_oe == 1'b0, "R14 reset sda", sda_oe, 0);
        check(store == 1'b0, "R8 reset store", store, 0);

        // R3: write and read every register with two patterns each
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 4; i++) begin
                vals[i] = 8'(8'h3C ^ (i * 37 + pass * 91));
                send_frame(ADDR, 8'(8'h20 + i), vals[i], 1'b1, 0, ack);
                check(ack == 1'b0, "R2 own address ack", ack, 0);
            end
            for (int i = 0; i < 4; i++) expect_reg(8'(8'h20 + i), vals[i], "R3 readback");
        end

        // R2: foreign address is ignored
        send_frame(7'h5B, 8'h20, 8'h99, 1'b1, 0, ack);
        check(ack == 1'b1, "R2 foreign nack", ack, 1);
        expect_reg(8'h20, vals[0], "R2 no change");

        // R4: receive byte follows last command code
        read_reg(8'h21, 1'b0, v, p, ep);
        recv(ADDR, ack, v);
        check(ack == 1'b0 && v == vals[1], "R4 receive byte", v, vals[1]);

        // R5: checksum on write and on read
        send_frame(ADDR, 8'h22, 8'hC3, 1'b1, 1, ack);
        read_reg(8'h22, 1'b1, v, p, ep);
        check(v == 8'hC3, "R5 write with checksum", v, 8'hC3);
        check(p == ep, "R5 read checksum", p, ep);
        read_reg(8'h23, 1'b1, v, p, ep);
        check(p == ep, "R5 read checksum 2", p, ep);

        // R6: bad checksum
        send_frame(ADDR, 8'h22, 8'h11, 1'b1, 2, ack);
        expect_reg(8'h22, 8'hC3, "R6 discarded");
        expect_reg(8'h7E, 8'h01, "R6 status bit");
        check(alert_n == 1'b0, "R6 alert", alert_n, 0);

        // R10/R11: alert response with only a communication error
        recv(ARA, ack, v);
        check(ack == 1'b0, "R10 alert response ack", ack, 0);
        check(v == {ADDR, 1'b0}, "R10 alert response data", v, {ADDR, 1'b0});
        waitc(200);
        check(alert_n == 1'b1, "R11 no reassert for comm error", alert_n, 1);
        recv(ARA, ack, v);
        check(ack == 1'b1, "R10 no ack without alert", ack, 1);

        // R9: clear error
        send_frame(ADDR, 8'h03, 8'h00, 1'b0, 0, ack);
        expect_reg(8'h7E, 8'h00, "R9 cleared");

        // R7: mandatory checksum
        pec_req = 1'b1;
        send_frame(ADDR, 8'h21, 8'h77, 1'b1, 0, ack);
        expect_reg(8'h21, vals[1], "R7 discarded");
        expect_reg(8'h7E, 8'h00, "R7 no status");
        send_frame(ADDR, 8'h21, 8'h77, 1'b1, 1, ack);
        expect_reg(8'h21, 8'h77, "R7 accepted with checksum");
        pec_req = 1'b0;

        // R8: commit command
        sc = store_cnt;
        send_frame(ADDR, 8'h15, 8'h00, 1'b0, 0, ack);
        waitc(4);
        check(store_cnt == sc + 1, "R8 store plain", store_cnt, sc + 1);
        send_frame(ADDR, 8'h15, 8'h00, 1'b0, 1, ack);
        waitc(4);
        check(store_cnt == sc + 2, "R8 store checksum", store_cnt, sc + 2);
        send_frame(ADDR, 8'h15, 8'h00, 1'b0, 2, ack);
        waitc(4);
        check(store_cnt == sc + 2, "R8 store bad checksum", store_cnt, sc + 2);
        send_frame(ADDR, 8'h20, 8'h15, 1'b1, 0, ack);
        waitc(4);
        check(store_cnt == sc + 2, "R8 no store on write", store_cnt, sc + 2);
        recv(ARA, ack, v);
        send_frame(ADDR, 8'h03, 8'h00, 1'b0, 0, ack);
        check(alert_n == 1'b1, "R10 alert cleared", alert_n, 1);

        // R10/R11: persistent fault
        fault = 2'b10;
        waitc(10);
        check(alert_n == 1'b0, "R10 fault alert", alert_n, 0);
        recv(ARA, ack, v);
        check(ack == 1'b0 && v == {ADDR, 1'b0}, "R10 fault response", v, {ADDR, 1'b0});
        check(alert_n == 1'b0, "R11 reassert persistent fault", alert_n, 0);
        fault = 2'b00;
        recv(ARA, ack, v);
        waitc(50);
        check(alert_n == 1'b1, "R11 released after fault gone", alert_n, 1);

        // R12: NACK on read releases SDA
        send_frame(ADDR, 8'h23, 8'h00, 1'b1, 0, ack);
        bus_start();
        wbyte({ADDR, 1'b0}, ack);
        wbyte(8'h23, ack);
        bus_start();
        wbyte({ADDR, 1'b1}, ack);
        rbyte(v);
        wbit(1'b1);
        rbyte(p);
        bus_stop();
        check(v == 8'h00, "R12 data before nack", v, 0);
        check(p == 8'hFF, "R12 released after nack", p, 8'hFF);

        // R1: glitches on SCL and SDA
        glitch_en = 1'b1;
        send_frame(ADDR, 8'h20, 8'h5D, 1'b1, 0, ack);
        glitch_en = 1'b0;
        expect_reg(8'h20, 8'h5D, "R1 glitch filtered");

        // R13: slower bus rates
        q_cyc = 31;
        send_frame(ADDR, 8'h21, 8'hE2, 1'b1, 1, ack);
        expect_reg(8'h21, 8'hE2, "R13 400 kHz");
        q_cyc = 125;
        send_frame(ADDR, 8'h22, 8'h4B, 1'b1, 0, ack);
        expect_reg(8'h22, 8'h4B, "R13 100 kHz");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule